// File: doc/BRIEF.md
# Reference Switchover Phase Build-Out Controller

This block sits in front of a digital loop and controls what happens to output phase when the loop moves from one reference input to another. Each of the references has a programmable selection rank, and one shared cut-off rank decides which references are allowed to steer the output phase. When a switch is requested, the block looks up the rank of the reference being switched to. If that rank is numerically below the cut-off, the new reference counts as a phase master. The block then clears any stored correction and lets the loop pull the output onto the new reference's phase.

For any other reference, the switch is a build-out. The block flags it for one cycle and enters a settling phase. It latches the first valid phase-error sample that follows as an offset, then subtracts that offset from every later sample until the next switch. The loop therefore sees no phase step at the moment of the change. A request that arrives during settling is held back and serviced as soon as the offset has been captured. If several requests arrive in that window, only the most recent one is kept.

Top module: `refsw_buildout_ctrl`

## Requirements
- R1: After reset the active reference is 0, the stored offset is 0, the build-out flag is low, and every rank register and the cut-off register hold 0.
- R2: A reference is a phase master only when its rank is strictly less than the cut-off. A rank equal to the cut-off is not a phase master.
- R3: An accepted switch changes the active reference output at the clock edge that samples the request.
- R4: A switch to a reference that is not a phase master raises the build-out flag for exactly one cycle, in the cycle after the request.
- R5: After a build-out switch, the first cycle with the phase-valid input high loads that cycle's signed phase error into the stored offset.
- R6: Outside settling, the corrected-valid output follows phase-valid and the corrected error equals phase error minus the stored offset (two's complement, 16 bits). During settling, corrected-valid stays low.
- R7: A switch to a phase master clears the stored offset to 0 at the accepting edge, does not raise the build-out flag and does not enter settling.
- R8: A request made while settling does not change the active reference. The latest such request is accepted at the first edge after the capture, with no further request needed.
- R9: With the cut-off at its reset value 0, no reference is a phase master.
- R10: A write to a rank register (select 0 to 3) or to the cut-off register takes effect for switches requested after the writing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prio_we | input | 1 | Write strobe for one rank register |
| prio_sel | input | 2 | Reference whose rank is written |
| prio_wdata | input | 3 | Rank value, lower means preferred |
| thr_we | input | 1 | Write strobe for the cut-off register |
| thr_wdata | input | 3 | Cut-off rank value |
| sw_req | input | 1 | Switch request, one cycle per request |
| sw_ref_idx | input | 2 | Reference to switch to |
| phase_vld | input | 1 | Phase error sample valid |
| phase_err | input | 16 | Signed measured phase error |
| active_ref | output | 2 | Currently selected reference |
| offset_hold | output | 16 | Stored signed build-out offset |
| buildout_pulse | output | 1 | One-cycle flag on a build-out switch |
| corr_vld | output | 1 | Corrected error valid |
| corr_err | output | 16 | Phase error minus stored offset |

## Verification
The situation that is hardest to reach from the ports is a burst of requests landing inside the settling window. In that case the active reference must stay frozen, and the stored request must then fire by itself one edge after capture. The stimulus reaches it by starting a build-out switch and keeping phase-valid low, so settling cannot end. Two further requests are issued during that window, and only then is a phase sample supplied. The checks confirm that the later of the two requests wins. A second corner is the rank exactly equal to the cut-off. It is reached by rewriting the cut-off to match one reference's rank before switching to that reference.

// File: rtl/refsw_pkg.sv
// Package: shared types for the reference switchover build-out controller.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package refsw_pkg;

    // Sequencer state: idle accepts requests, settle waits for offset capture.
    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_SETTLE = 1'b1
    } seq_state_e;

endpackage

// File: rtl/refsw_prio_regs.sv
// Module: refsw_prio_regs
// Holds one rank register per reference plus the shared cut-off register.
// It reports whether the looked-up candidate reference is a phase master,
// meaning its rank is strictly below the cut-off.
// Assumes: synchronous active-low reset, and all registers reset to 0.
module refsw_prio_regs #(
    parameter int NUM_REFS = 4,
    parameter int PRIO_W   = 3,
    parameter int IDX_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prio_we,
    input  logic [IDX_W-1:0]  prio_sel,
    input  logic [PRIO_W-1:0] prio_wdata,
    input  logic              thr_we,
    input  logic [PRIO_W-1:0] thr_wdata,
    input  logic [IDX_W-1:0]  look_idx,
    output logic              look_is_master
);

    logic [PRIO_W-1:0] prio_q [NUM_REFS];
    logic [PRIO_W-1:0] thr_q;

    // One rank register per reference profile.
    for (genvar g = 0; g < NUM_REFS; g++) begin : g_prof
        // Load this profile's rank when it is selected for writing.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q[g] <= '0;
            end else if (prio_we && (prio_sel == IDX_W'(g))) begin
                prio_q[g] <= prio_wdata;
            end
        end
    end

    // Shared cut-off register; its reset value of 0 means no masters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (thr_we) begin
            thr_q <= thr_wdata;
        end
    end

    // Compare the candidate's rank against the cut-off (strictly lower wins).
    always_comb begin
        look_is_master = (prio_q[look_idx] < thr_q);
    end

endmodule

// File: rtl/refsw_seq.sv
// Module: refsw_seq
// Switch sequencer. It accepts a request when idle, updates the active
// reference and decides between a master switch and a build-out switch.
// A build-out switch holds it in settle until the first valid phase sample.
// Requests seen while settling are parked; the latest one wins and is
// serviced at the first edge after capture.
// Assumes: sw_req is a one-cycle strobe per request.
module refsw_seq
    import refsw_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_req,
    input  logic [IDX_W-1:0] sw_ref_idx,
    input  logic             phase_vld,
    input  logic             cand_is_master,
    output logic [IDX_W-1:0] cand_idx,
    output logic [IDX_W-1:0] active_ref,
    output logic             settling,
    output logic             accept,
    output logic             accept_master,
    output logic             capture,
    output logic             buildout_pulse
);

    seq_state_e       state_q;
    logic             pend_vld_q;
    logic [IDX_W-1:0] pend_idx_q;

    // Pick the request to serve: a parked one has precedence over a new one.
    always_comb begin
        cand_idx      = pend_vld_q ? pend_idx_q : sw_ref_idx;
        accept        = (state_q == SEQ_IDLE) && (pend_vld_q || sw_req);
        accept_master = accept && cand_is_master;
        capture       = (state_q == SEQ_SETTLE) && phase_vld;
        settling      = (state_q == SEQ_SETTLE);
    end

    // State, active reference, build-out flag and parked-request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= SEQ_IDLE;
            active_ref     <= '0;
            buildout_pulse <= 1'b0;
            pend_vld_q     <= 1'b0;
            pend_idx_q     <= '0;
        end else if (accept) begin
            active_ref     <= cand_idx;
            state_q        <= cand_is_master ? SEQ_IDLE : SEQ_SETTLE;
            buildout_pulse <= !cand_is_master;
            if (pend_vld_q && sw_req) begin
                pend_idx_q <= sw_ref_idx;
            end else begin
                pend_vld_q <= 1'b0;
            end
        end else begin
            buildout_pulse <= 1'b0;
            if (state_q == SEQ_SETTLE) begin
                if (sw_req) begin
                    pend_vld_q <= 1'b1;
                    pend_idx_q <= sw_ref_idx;
                end
                if (phase_vld) begin
                    state_q <= SEQ_IDLE;
                end
            end
        end
    end

endmodule

// File: rtl/refsw_offset.sv
// Module: refsw_offset
// Stores the build-out offset and produces the corrected phase error.
// A master switch clears the offset. A capture loads the current sample.
// Corrected output is suppressed while the sequencer is settling.
// Assumes: accept and capture never occur in the same cycle.
module refsw_offset #(
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept_master,
    input  logic               capture,
    input  logic               settling,
    input  logic               phase_vld,
    input  logic [PHASE_W-1:0] phase_err,
    output logic [PHASE_W-1:0] offset_hold,
    output logic               corr_vld,
    output logic [PHASE_W-1:0] corr_err
);

    // Offset register: cleared on a master switch, loaded on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_hold <= '0;
        end else if (accept_master) begin
            offset_hold <= '0;
        end else if (capture) begin
            offset_hold <= phase_err;
        end
    end

    // Subtract the stored offset and gate validity with the settle state.
    always_comb begin
        corr_err = phase_err - offset_hold;
        corr_vld = phase_vld && !settling;
    end

endmodule

// File: rtl/refsw_buildout_ctrl.sv
// Module: refsw_buildout_ctrl (top)
// Reference switchover controller with build-out versus master decision.
// It ties together the rank registers, the switch sequencer and the
// offset/correction stage.
// Assumes: synchronous active-low reset; NUM_REFS is a power of two.
module refsw_buildout_ctrl #(
    parameter int NUM_REFS = 4,
    parameter int PRIO_W   = 3,
    parameter int PHASE_W  = 16,
    localparam int IDX_W   = $clog2(NUM_REFS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prio_we,
    input  logic [IDX_W-1:0]   prio_sel,
    input  logic [PRIO_W-1:0]  prio_wdata,
    input  logic               thr_we,
    input  logic [PRIO_W-1:0]  thr_wdata,
    input  logic               sw_req,
    input  logic [IDX_W-1:0]   sw_ref_idx,
    input  logic               phase_vld,
    input  logic [PHASE_W-1:0] phase_err,
    output logic [IDX_W-1:0]   active_ref,
    output logic [PHASE_W-1:0] offset_hold,
    output logic               buildout_pulse,
    output logic               corr_vld,
    output logic [PHASE_W-1:0] corr_err
);

    logic [IDX_W-1:0] cand_idx;
    logic             cand_is_master;
    logic             settling;
    logic             accept;
    logic             accept_master;
    logic             capture;

    refsw_prio_regs #(
        .NUM_REFS (NUM_REFS),
        .PRIO_W   (PRIO_W),
        .IDX_W    (IDX_W)
    ) i_prio (
        .clk            (clk),
        .rst_n          (rst_n),
        .prio_we        (prio_we),
        .prio_sel       (prio_sel),
        .prio_wdata     (prio_wdata),
        .thr_we         (thr_we),
        .thr_wdata      (thr_wdata),
        .look_idx       (cand_idx),
        .look_is_master (cand_is_master)
    );

    refsw_seq #(
        .IDX_W (IDX_W)
    ) i_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .sw_req         (sw_req),
        .sw_ref_idx     (sw_ref_idx),
        .phase_vld      (phase_vld),
        .cand_is_master (cand_is_master),
        .cand_idx       (cand_idx),
        .active_ref     (active_ref),
        .settling       (settling),
        .accept         (accept),
        .accept_master  (accept_master),
        .capture        (capture),
        .buildout_pulse (buildout_pulse)
    );

    refsw_offset #(
        .PHASE_W (PHASE_W)
    ) i_off (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept_master (accept_master),
        .capture       (capture),
        .settling      (settling),
        .phase_vld     (phase_vld),
        .phase_err     (phase_err),
        .offset_hold   (offset_hold),
        .corr_vld      (corr_vld),
        .corr_err      (corr_err)
    );

endmodule

// File: rtl/refsw_buildout_chk.sv
// Module: refsw_buildout_chk
// Assertion checker bound to refsw_buildout_ctrl. It relates sequencer
// events to the offset register and the output flags over time.
module refsw_buildout_chk #(
    parameter int IDX_W   = 2,
    parameter int PHASE_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               accept,
    input logic               accept_master,
    input logic               capture,
    input logic               settling,
    input logic               phase_vld,
    input logic [PHASE_W-1:0] phase_err,
    input logic [IDX_W-1:0]   active_ref,
    input logic [PHASE_W-1:0] offset_hold,
    input logic               buildout_pulse,
    input logic               corr_vld
);

    // R4: the build-out flag never lasts longer than one cycle.
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        buildout_pulse |=> !buildout_pulse);

    // R4: the flag is only seen while settling after a build-out switch.
    p_pulse_in_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        buildout_pulse |-> settling);

    // R5: a capture loads exactly the sample presented in that cycle.
    p_capture_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (offset_hold == $past(phase_err)));

    // R6: no corrected output is valid while settling.
    p_no_corr_settle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        settling |-> !corr_vld);

    // R7: a master switch leaves a zero offset.
    p_master_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept_master |=> (offset_hold == '0));

    // R7: a master switch never produces the build-out flag.
    p_master_no_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept_master |=> !buildout_pulse);

    // R8: the active reference is frozen while settling.
    p_hold_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        settling |=> $stable(active_ref));

    // R5: without a capture or a switch, the offset does not move.
    p_offset_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(capture || accept) |=> $stable(offset_hold));

    // R8: no switch is accepted in a cycle that also captures.
    p_no_accept_on_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !accept);

    // R6: a capture implies a valid sample.
    p_capture_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> phase_vld);

endmodule

bind refsw_buildout_ctrl refsw_buildout_chk #(
    .IDX_W   (IDX_W),
    .PHASE_W (PHASE_W)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .accept         (accept),
    .accept_master  (accept_master),
    .capture        (capture),
    .settling       (settling),
    .phase_vld      (phase_vld),
    .phase_err      (phase_err),
    .active_ref     (active_ref),
    .offset_hold    (offset_hold),
    .buildout_pulse (buildout_pulse),
    .corr_vld       (corr_vld)
);

// File: tb/test_refsw_buildout_ctrl.sv
`timescale 1ns/1ps
module test_refsw_buildout_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        prio_we;
    logic [1:0]  prio_sel;
    logic [2:0]  prio_wdata;
    logic        thr_we;
    logic [2:0]  thr_wdata;
    logic        sw_req;
    logic [1:0]  sw_ref_idx;
    logic        phase_vld;
    logic [15:0] phase_err;
    logic [1:0]  active_ref;
    logic [15:0] offset_hold;
    logic        buildout_pulse;
    logic        corr_vld;
    logic [15:0] corr_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Bench model of the configuration registers.
    int m_prio [4];
    int m_thr;

    typedef struct packed {
        logic [1:0]         idx;
        logic signed [15:0] cap;
        logic signed [15:0] nxt;
        logic               bo;
    } vec_t;

    // Ranks 0,2,5,7 with cut-off 3: references 0 and 1 are masters.
    localparam vec_t VECS [6] = '{
        '{2'd2,  16'sd120,  16'sd150, 1'b1},
        '{2'd3, -16'sd40,  -16'sd10,  1'b1},
        '{2'd1,  16'sd300,  16'sd310, 1'b0},
        '{2'd2, -16'sd500, -16'sd480, 1'b1},
        '{2'd0,  16'sd77,   16'sd90,  1'b0},
        '{2'd3,  16'sd1000, 16'sd999, 1'b1}
    };

    always #2.5 clk = ~clk;

    refsw_buildout_ctrl i_refsw_buildout_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .prio_we        (prio_we),
        .prio_sel       (prio_sel),
        .prio_wdata     (prio_wdata),
        .thr_we         (thr_we),
        .thr_wdata      (thr_wdata),
        .sw_req         (sw_req),
        .sw_ref_idx     (sw_ref_idx),
        .phase_vld      (phase_vld),
        .phase_err      (phase_err),
        .active_ref     (active_ref),
        .offset_hold    (offset_hold),
        .buildout_pulse (buildout_pulse),
        .corr_vld       (corr_vld),
        .corr_err       (corr_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_prio(input int sel, input int val);
        prio_we = 1'b1; prio_sel = 2'(sel); prio_wdata = 3'(val);
        @(negedge clk);
        prio_we = 1'b0;
        m_prio[sel] = val;
    endtask

    task automatic write_thr(input int val);
        thr_we = 1'b1; thr_wdata = 3'(val);
        @(negedge clk);
        thr_we = 1'b0;
        m_thr = val;
    endtask

    // Issue a one-cycle request; returns at the negedge after the accepting edge.
    task automatic req_switch(input int idx);
        sw_req = 1'b1; sw_ref_idx = 2'(idx);
        @(negedge clk);
        sw_req = 1'b0;
    endtask

    // Present one valid sample; returns at the negedge after that edge.
    task automatic phase_cycle(input int val);
        phase_vld = 1'b1; phase_err = 16'(val);
        @(negedge clk);
        phase_vld = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; prio_we = 1'b0; prio_sel = '0; prio_wdata = '0;
        thr_we = 1'b0; thr_wdata = '0; sw_req = 1'b0; sw_ref_idx = '0;
        phase_vld = 1'b0; phase_err = '0;
        for (int i = 0; i < 4; i++) m_prio[i] = 0;
        m_thr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports.
        check("R1 active_ref", int'(active_ref), 0);
        check("R1 offset_hold", int'(offset_hold), 0);
        check("R1 buildout_pulse", int'(buildout_pulse), 0);

        // R9: cut-off 0 after reset, so rank-0 reference 1 is not a master.
        req_switch(1);
        check("R3 active after switch", int'(active_ref), 1);
        check("R9 flag with cut-off 0", int'(buildout_pulse), 1);
        phase_cycle(50);
        check("R5 offset capture", int'($signed(offset_hold)), 50);
        check("R4 flag drops", int'(buildout_pulse), 0);

        // R10: program ranks and cut-off, then switch to a master.
        write_prio(0, 0); write_prio(1, 2); write_prio(2, 5); write_prio(3, 7);
        write_thr(3);
        req_switch(1);
        check("R10 master after write", int'(buildout_pulse), 0);
        check("R7 offset cleared", int'(offset_hold), 0);
        phase_vld = 1'b1; phase_err = 16'(25); #1;
        check("R7 no settle corr_vld", int'(corr_vld), 1);
        check("R7 zero correction", int'($signed(corr_err)), 25);
        @(negedge clk); phase_vld = 1'b0;

        // R2: rank equal to cut-off is not a master.
        write_thr(5);
        req_switch(2);
        check("R2 equal rank builds out", int'(buildout_pulse), 1);
        phase_cycle(-7);
        check("R5 signed capture", int'($signed(offset_hold)), -7);
        write_thr(3);

        // Table walk: switch, capture, then corrected sample.
        foreach (VECS[k]) begin
            automatic bit exp_bo = !(m_prio[VECS[k].idx] < m_thr);
            automatic int exp_off = exp_bo ? int'(VECS[k].cap) : 0;
            check("R2 table model", int'(exp_bo), int'(VECS[k].bo));
            req_switch(int'(VECS[k].idx));
            check("R3 table active_ref", int'(active_ref), int'(VECS[k].idx));
            check("R4 table flag", int'(buildout_pulse), int'(exp_bo));
            if (!exp_bo) check("R7 table offset zero", int'(offset_hold), 0);
            phase_vld = 1'b1; phase_err = VECS[k].cap; #1;
            check("R6 corr_vld at first sample", int'(corr_vld), int'(!exp_bo));
            @(negedge clk);
            check("R5 table offset", int'($signed(offset_hold)), exp_off);
            check("R4 table flag low", int'(buildout_pulse), 0);
            phase_err = VECS[k].nxt; #1;
            check("R6 corr_vld after", int'(corr_vld), 1);
            check("R6 corrected error", int'($signed(corr_err)),
                  int'(VECS[k].nxt) - exp_off);
            @(negedge clk); phase_vld = 1'b0;
        end

        // R8: requests during settling are parked; latest wins.
        req_switch(2);
        check("R4 hold-off start flag", int'(buildout_pulse), 1);
        req_switch(1);
        check("R8 frozen after first parked", int'(active_ref), 2);
        req_switch(3);
        check("R8 frozen after second parked", int'(active_ref), 2);
        check("R6 corr_vld low in settle", int'(corr_vld), 0);
        phase_cycle(200);
        check("R5 capture before parked", int'($signed(offset_hold)), 200);
        check("R8 still frozen at capture", int'(active_ref), 2);
        @(negedge clk);
        check("R8 parked accepted", int'(active_ref), 3);
        check("R8 parked builds out", int'(buildout_pulse), 1);
        phase_cycle(33);
        check("R5 parked capture", int'($signed(offset_hold)), 33);
        @(negedge clk);
        check("R8 no stale parked", int'(active_ref), 3);

        // R1: reset mid-operation restores defaults, including cut-off 0.
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        check("R1 reset offset", int'(offset_hold), 0);
        check("R1 reset active", int'(active_ref), 0);
        m_thr = 0;
        req_switch(0);
        check("R1 cut-off back to 0", int'(buildout_pulse), 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule